// File: doc/BRIEF.md
# Two-Stage Lookahead Wormhole Router

A five-port wormhole router for one node of a 2-D mesh. The ports are local, X+, X-, Y+ and Y-. Each packet is a head flit, any number of body flits and a tail flit. A packet can also be a single flit that is both head and tail. Every head flit carries a 3-bit output field. The previous router filled it in, so this router needs no route computation before it can steer the head. While a head is being written into its input buffer, this router works out the port that the next router will need and writes that value into the head's output field.

Each input has a small buffer with head and tail pointers. Every buffered flit carries the output it must leave through. Each output has its own allocator. The allocator picks one input using round robin and locks onto that input until the packet's tail has left. A multiplexer per output reads the granted input's front flit into an output register with a valid/ready handshake. A flit is accepted on one clock edge and appears in the output register after the next edge, so one hop costs two cycles.

Top module: `lar_router`

## Requirements
- R1: After reset every `out_valid` bit is low and every `in_ready` bit is high.
- R2: A flit accepted at one clock edge appears in the output register after the following edge, and not earlier.
- R3: Port codes are 0 local, 1 X+, 2 X-, 3 Y+, 4 Y-. A head or single flit leaves through the output named by its output field, bits [18:16]. Body and tail flits leave through the output of their packet's head.
- R4: The flit layout is kind [20:19], output field [18:16] and payload [15:0]. The kind codes are 00 body, 01 head, 10 tail and 11 single. In a head, the destination X is in payload [3:2] and the destination Y is in [1:0]. The router is at (`MY_X`,`MY_Y`). A forwarded head or single flit has its output field replaced by the port chosen at the neighbour it is sent to: X+ if the destination X is larger than the neighbour's X, X- if it is smaller, otherwise Y+ or Y- by the same test on Y, and local when both are equal. A head sent to the local port keeps local. All other bits, and all body and tail flits, pass unchanged.
- R5: Once a head (01) wins an output, that output carries only flits from the same input until the tail (10) has passed. Heads from other inputs wait.
- R6: When several heads compete for an unlocked output, the search starts at the input after the one that last won that output.
- R7: While `out_valid` is high and `out_ready` is low, the output flit holds stable. No flit is lost or duplicated.
- R8: Each input buffers `DEPTH` flits and drops `in_ready` when full. With the output stalled, one input accepts `DEPTH`+1 flits, the extra one sitting in the output register.
- R9: Flits from different inputs going to different outputs move in the same cycle.
- R10: A single flit (11) leaves its output unlocked, so another input can win that output in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 5 | Flit offered on each input |
| in_flit | input | 5x21 | Flit on each input |
| in_ready | output | 5 | Input buffer has room |
| out_valid | output | 5 | Output register holds a flit |
| out_flit | output | 5x21 | Flit on each output |
| out_ready | input | 5 | Downstream takes the output flit |

## Verification
A corrupted route tag in a buffer entry sends a flit to the wrong output exactly one edge after the flit was accepted. A corrupted route rewrite shows at once as a wrong output field in the forwarded head. A lock that is never cleared leaves a waiting head stuck. A lock that is cleared too early lets a foreign flit into the middle of a packet. Either error shows in the order of flits on the shared output within a few cycles. A buffer pointer error shows as `in_ready` falling at the wrong fill level, or as a lost or repeated flit while the output drains.

// File: rtl/lar_router_pkg.sv
`timescale 1ns/1ps
package lar_router_pkg;
    localparam int NPORTS  = 5;
    localparam int PORT_W  = 3;
    localparam int DATA_W  = 16;
    localparam int COORD_W = 2;
    localparam int FLIT_W  = 2 + PORT_W + DATA_W;

    localparam logic [PORT_W-1:0] P_LOCAL = 3'd0;
    localparam logic [PORT_W-1:0] P_XP    = 3'd1;
    localparam logic [PORT_W-1:0] P_XM    = 3'd2;
    localparam logic [PORT_W-1:0] P_YP    = 3'd3;
    localparam logic [PORT_W-1:0] P_YM    = 3'd4;

    typedef enum logic [1:0] {K_BODY = 2'b00, K_HEAD = 2'b01,
                              K_TAIL = 2'b10, K_SINGLE = 2'b11} kind_e;

    typedef struct packed {
        kind_e               kind;
        logic [PORT_W-1:0]   oc;
        logic [DATA_W-1:0]   data;
    } flit_t;

    // buffer entry: output used at this router plus the (rewritten) flit
    typedef struct packed {
        logic [PORT_W-1:0] sel;
        flit_t             f;
    } bufent_t;

    function automatic logic starts_packet(input kind_e k);
        return (k == K_HEAD) || (k == K_SINGLE);
    endfunction

    // dimension ordered choice: X first, then Y, local when both match
    function automatic logic [PORT_W-1:0] dor_next(
        input logic [COORD_W-1:0] hx, input logic [COORD_W-1:0] hy,
        input logic [COORD_W-1:0] dx, input logic [COORD_W-1:0] dy);
        if (dx > hx)      return P_XP;
        else if (dx < hx) return P_XM;
        else if (dy > hy) return P_YP;
        else if (dy < hy) return P_YM;
        else              return P_LOCAL;
    endfunction

    // round robin: first requester after the last winner
    function automatic void rr_pick(input logic [NPORTS-1:0] req,
                                    input logic [PORT_W-1:0] last,
                                    output logic hit,
                                    output logic [PORT_W-1:0] idx);
        int c;
        hit = 1'b0;
        idx = last;
        for (int k = 1; k <= NPORTS; k++) begin
            c = (int'(last) + k) % NPORTS;
            if (!hit && req[c]) begin
                hit = 1'b1;
                idx = PORT_W'(c);
            end
        end
    endfunction
endpackage

// File: rtl/lar_lookahead.sv
`timescale 1ns/1ps
module lar_lookahead
    import lar_router_pkg::*;
#(
    parameter int MY_X = 1,
    parameter int MY_Y = 1
) (
    input  flit_t fin,
    output flit_t fout
);
    logic [COORD_W-1:0] nx, ny, dx, dy;

    always_comb begin
        nx = COORD_W'(MY_X);
        ny = COORD_W'(MY_Y);
        case (fin.oc)
            P_XP:    nx = nx + COORD_W'(1);
            P_XM:    nx = nx - COORD_W'(1);
            P_YP:    ny = ny + COORD_W'(1);
            P_YM:    ny = ny - COORD_W'(1);
            default: ;
        endcase
        dx = fin.data[2*COORD_W-1:COORD_W];
        dy = fin.data[COORD_W-1:0];
        fout = fin;
        if (starts_packet(fin.kind)) begin
            fout.oc = (fin.oc == P_LOCAL) ? P_LOCAL : dor_next(nx, ny, dx, dy);
        end
    end
endmodule

// File: rtl/lar_flit_buf.sv
`timescale 1ns/1ps
module lar_flit_buf #(
    parameter int DEPTH = 2,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp[AW-1:0]] <= din;
    end

    assign empty = (wp == rp);
    assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign dout  = mem[rp[AW-1:0]];

    // R8: a full buffer stays full until something is read
    a_r8_full_holds: assert property (@(posedge clk) disable iff (rst)
        full && !pop |=> full);
    // R8: the front entry is not disturbed by writes while it waits
    a_r8_front_kept: assert property (@(posedge clk) disable iff (rst)
        !empty && !pop |=> !empty && (dout == $past(dout)));
endmodule

// File: rtl/lar_out_alloc.sv
`timescale 1ns/1ps
module lar_out_alloc
    import lar_router_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NPORTS-1:0]              req_head,
    input  logic [NPORTS-1:0]              req_cont,
    input  logic [NPORTS-1:0][FLIT_W-1:0]  front,
    input  logic                           out_ready,
    output logic [NPORTS-1:0]              gnt,
    output logic                           out_valid,
    output logic [FLIT_W-1:0]              out_flit
);
    logic              locked;
    logic [PORT_W-1:0] owner, rr_last, sel, rr_idx;
    logic              have, rr_hit, can_load, fire;
    flit_t             pick;

    always_comb begin
        rr_pick(req_head, rr_last, rr_hit, rr_idx);
        if (locked) begin
            sel  = owner;
            have = req_cont[owner];
        end else begin
            sel  = rr_idx;
            have = rr_hit;
        end
    end

    assign can_load = !out_valid || out_ready;
    assign fire     = have && can_load;
    assign pick     = flit_t'(front[sel]);
    assign gnt      = fire ? (NPORTS'(1) << sel) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_flit  <= '0;
            locked    <= 1'b0;
            owner     <= '0;
            rr_last   <= PORT_W'(NPORTS - 1);
        end else begin
            if (fire) begin
                out_valid <= 1'b1;
                out_flit  <= front[sel];
                if (!locked) rr_last <= sel;
                if (pick.kind == K_HEAD) begin
                    locked <= 1'b1;
                    owner  <= sel;
                end else if (pick.kind == K_TAIL) begin
                    locked <= 1'b0;
                end
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    // R7: stalled output holds its flit
    a_r7_hold_out: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_flit));
    // R5: lock and owner persist until the tail leaves
    a_r5_owner_kept: assert property (@(posedge clk) disable iff (rst)
        locked && !(fire && pick.kind == K_TAIL) |=> locked && $stable(owner));
    // R10: a single-flit packet does not lock the output
    a_r10_single_no_lock: assert property (@(posedge clk) disable iff (rst)
        fire && !locked && pick.kind == K_SINGLE |=> !locked);
endmodule

// File: rtl/lar_router.sv
`timescale 1ns/1ps
module lar_router
    import lar_router_pkg::*;
#(
    parameter int MY_X  = 1,
    parameter int MY_Y  = 1,
    parameter int DEPTH = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NPORTS-1:0]             in_valid,
    input  logic [NPORTS-1:0][FLIT_W-1:0] in_flit,
    output logic [NPORTS-1:0]             in_ready,
    output logic [NPORTS-1:0]             out_valid,
    output logic [NPORTS-1:0][FLIT_W-1:0] out_flit,
    input  logic [NPORTS-1:0]             out_ready
);
    localparam int ENT_W = $bits(bufent_t);

    flit_t                         raw_f   [NPORTS];
    flit_t                         ahead_f [NPORTS];
    bufent_t                       wr_ent  [NPORTS];
    bufent_t                       rd_ent  [NPORTS];
    logic [PORT_W-1:0]             wr_route[NPORTS];
    logic [NPORTS-1:0]             push, pop, empty, full;
    logic [NPORTS-1:0]             req_h [NPORTS];
    logic [NPORTS-1:0]             req_c [NPORTS];
    logic [NPORTS-1:0]             gnt   [NPORTS];
    logic [NPORTS-1:0]             gcol  [NPORTS];
    logic [NPORTS-1:0][FLIT_W-1:0] front_flat;

    // stage 1: route lookahead and buffer write per input
    for (genvar i = 0; i < NPORTS; i++) begin : g_in
        assign raw_f[i] = flit_t'(in_flit[i]);

        lar_lookahead #(.MY_X(MY_X), .MY_Y(MY_Y)) u_la (
            .fin (raw_f[i]),
            .fout(ahead_f[i])
        );

        assign push[i]     = in_valid[i] && !full[i];
        assign in_ready[i] = !full[i];
        assign wr_ent[i].f   = ahead_f[i];
        assign wr_ent[i].sel = starts_packet(raw_f[i].kind) ? raw_f[i].oc : wr_route[i];

        always_ff @(posedge clk) begin
            if (rst) wr_route[i] <= P_LOCAL;
            else if (push[i] && starts_packet(raw_f[i].kind)) wr_route[i] <= raw_f[i].oc;
        end

        lar_flit_buf #(.DEPTH(DEPTH), .W(ENT_W)) u_buf (
            .clk  (clk),
            .rst  (rst),
            .push (push[i]),
            .din  (wr_ent[i]),
            .pop  (pop[i]),
            .dout (rd_ent[i]),
            .empty(empty[i]),
            .full (full[i])
        );

        assign front_flat[i] = rd_ent[i].f;

        // R9: an input is granted by at most one output per cycle
        a_r9_one_grant: assert property (@(posedge clk) disable iff (rst)
            $onehot0(gcol[i]));
    end

    // requests toward each output
    always_comb begin
        for (int o = 0; o < NPORTS; o++) begin
            for (int i = 0; i < NPORTS; i++) begin
                req_h[o][i] = !empty[i] && (rd_ent[i].sel == PORT_W'(o))
                              && starts_packet(rd_ent[i].f.kind);
                req_c[o][i] = !empty[i] && (rd_ent[i].sel == PORT_W'(o))
                              && !starts_packet(rd_ent[i].f.kind);
            end
        end
    end

    // stage 2: allocation, crossbar and output register per output
    for (genvar o = 0; o < NPORTS; o++) begin : g_out
        lar_out_alloc u_alloc (
            .clk      (clk),
            .rst      (rst),
            .req_head (req_h[o]),
            .req_cont (req_c[o]),
            .front    (front_flat),
            .out_ready(out_ready[o]),
            .gnt      (gnt[o]),
            .out_valid(out_valid[o]),
            .out_flit (out_flit[o])
        );
    end

    always_comb begin
        pop = '0;
        for (int i = 0; i < NPORTS; i++) begin
            for (int o = 0; o < NPORTS; o++) begin
                gcol[i][o] = gnt[o][i];
                pop[i]     = pop[i] | gnt[o][i];
            end
        end
    end
endmodule

// File: tb/lar_router_test.sv
`timescale 1ns/1ps
module lar_router_test;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [4:0]        in_valid = '0;
    logic [4:0][20:0]  in_flit  = '0;
    logic [4:0]        in_ready;
    logic [4:0]        out_valid;
    logic [4:0][20:0]  out_flit;
    logic [4:0]        out_ready = '1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    lar_router #(.MY_X(1), .MY_Y(1), .DEPTH(2)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_flit(in_flit),
        .in_ready(in_ready), .out_valid(out_valid), .out_flit(out_flit),
        .out_ready(out_ready)
    );

    // kinds: 00 body, 01 head, 10 tail, 11 single
    function automatic logic [20:0] mk(input logic [1:0] k, input logic [2:0] oc,
                                       input logic [15:0] d);
        return {k, oc, d};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // recorder for local output (port 0)
    logic [20:0] rec [16];
    int rcnt = 0;
    always @(negedge clk) begin
        if (out_valid[0] && out_ready[0] && rcnt < 16) begin
            rec[rcnt] = out_flit[0];
            rcnt++;
        end
    end

    // vectors: in port, output field, dest x, dest y, expected rewritten field
    localparam logic [12:0] VEC [8] = '{
        {3'd0, 3'd1, 2'd3, 2'd2, 3'd1},
        {3'd2, 3'd1, 2'd2, 2'd3, 3'd3},
        {3'd1, 3'd2, 2'd0, 2'd0, 3'd4},
        {3'd4, 3'd3, 2'd1, 2'd2, 3'd0},
        {3'd3, 3'd4, 2'd3, 2'd0, 3'd1},
        {3'd0, 3'd2, 2'd0, 2'd1, 3'd0},
        {3'd2, 3'd3, 2'd0, 2'd3, 3'd2},
        {3'd3, 3'd0, 2'd1, 2'd1, 3'd0}
    };

    logic [2:0]  ip, oc, ex;
    logic [15:0] d;
    int acc, n;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 out_valid after reset", 32'(out_valid), 32'h0);
        chk("R1 in_ready after reset",  32'(in_ready),  32'h1f);

        // table walk: route, timing and lookahead rewrite
        for (int v = 0; v < 8; v++) begin
            ip = VEC[v][12:10];
            oc = VEC[v][9:7];
            ex = VEC[v][2:0];
            d  = {8'hC0, 4'(v), VEC[v][6:5], VEC[v][4:3]};
            in_flit[ip]  = mk(2'b11, oc, d);
            in_valid[ip] = 1'b1;
            @(negedge clk);
            in_valid[ip] = 1'b0;
            chk("R2 not before second edge", 32'(out_valid), 32'h0);
            @(negedge clk);
            chk("R3 output chosen by field", 32'(out_valid), 32'(5'b1 << oc));
            chk("R4 rewritten head", 32'(out_flit[oc]), 32'(mk(2'b11, ex, d)));
        end
        repeat (3) @(negedge clk);

        // wormhole lock: input 1 packet vs input 2 single on output 0
        rcnt = 0;
        in_flit[1] = mk(2'b01, 3'd0, 16'h1105); in_valid[1] = 1'b1;
        in_flit[2] = mk(2'b11, 3'd0, 16'h2205); in_valid[2] = 1'b1;
        @(negedge clk);
        in_valid[2] = 1'b0;
        in_flit[1] = mk(2'b00, 3'd5, 16'hB0D1);
        @(negedge clk);
        in_flit[1] = mk(2'b10, 3'd6, 16'h7A11);
        @(negedge clk);
        in_valid[1] = 1'b0;
        repeat (6) @(negedge clk);
        chk("R5 flit count", 32'(rcnt), 32'd4);
        chk("R5 head first",   32'(rec[0]), 32'(mk(2'b01, 3'd0, 16'h1105)));
        chk("R4 body unchanged", 32'(rec[1]), 32'(mk(2'b00, 3'd5, 16'hB0D1)));
        chk("R4 tail unchanged", 32'(rec[2]), 32'(mk(2'b10, 3'd6, 16'h7A11)));
        chk("R5 waiting head after tail", 32'(rec[3]), 32'(mk(2'b11, 3'd0, 16'h2205)));

        // round robin among singles (last winner on output 0 is input 2)
        rcnt = 0;
        in_flit[1] = mk(2'b11, 3'd0, 16'h3105); in_valid[1] = 1'b1;
        in_flit[3] = mk(2'b11, 3'd0, 16'h3305); in_valid[3] = 1'b1;
        @(negedge clk);
        in_valid = '0;
        repeat (4) @(negedge clk);
        in_flit[1] = mk(2'b11, 3'd0, 16'h3115); in_valid[1] = 1'b1;
        in_flit[2] = mk(2'b11, 3'd0, 16'h3205); in_valid[2] = 1'b1;
        @(negedge clk);
        in_valid = '0;
        repeat (4) @(negedge clk);
        chk("R10 singles all delivered", 32'(rcnt), 32'd4);
        chk("R6 rotation picks input 3", 32'(rec[0]), 32'(mk(2'b11, 3'd0, 16'h3305)));
        chk("R10 next input wins at once", 32'(rec[1]), 32'(mk(2'b11, 3'd0, 16'h3105)));
        chk("R6 rotation picks input 2", 32'(rec[2]), 32'(mk(2'b11, 3'd0, 16'h3205)));
        chk("R6 then input 1",           32'(rec[3]), 32'(mk(2'b11, 3'd0, 16'h3115)));

        // backpressure on output 1
        out_ready[1] = 1'b0;
        in_flit[0] = mk(2'b11, 3'd1, 16'h400D); in_valid[0] = 1'b1;
        @(negedge clk);
        in_valid[0] = 1'b0;
        in_flit[2] = mk(2'b11, 3'd1, 16'h420D); in_valid[2] = 1'b1;
        @(negedge clk);
        in_valid[2] = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R7 valid held", 32'(out_valid[1]), 32'd1);
            chk("R7 flit held",  32'(out_flit[1]), 32'(mk(2'b11, 3'd1, 16'h400D)));
            @(negedge clk);
        end
        out_ready[1] = 1'b1;
        @(negedge clk);
        chk("R7 second flit follows", 32'(out_flit[1]), 32'(mk(2'b11, 3'd1, 16'h420D)));
        chk("R7 second flit valid",   32'(out_valid[1]), 32'd1);
        @(negedge clk);
        chk("R7 no duplicate", 32'(out_valid[1]), 32'd0);

        // buffer fill on input 4 with output 3 stalled
        out_ready[3] = 1'b0;
        in_flit[4] = mk(2'b11, 3'd3, 16'h5006); in_valid[4] = 1'b1;
        acc = 0;
        for (int k = 0; k < 5; k++) begin
            if (in_ready[4]) acc++;
            @(negedge clk);
        end
        chk("R8 accepted DEPTH+1", 32'(acc), 32'd3);
        chk("R8 ready low when full", 32'(in_ready[4]), 32'd0);
        in_valid[4] = 1'b0;
        out_ready[3] = 1'b1;
        n = 0;
        for (int k = 0; k < 8; k++) begin
            if (out_valid[3]) begin
                n++;
                chk("R4 buffered head rewritten", 32'(out_flit[3]),
                    32'(mk(2'b11, 3'd0, 16'h5006)));
            end
            @(negedge clk);
        end
        chk("R8 drained count", 32'(n), 32'd3);
        chk("R8 ready back", 32'(in_ready[4]), 32'd1);

        // parallel transfers to two outputs
        in_flit[0] = mk(2'b11, 3'd1, 16'h600D); in_valid[0] = 1'b1;
        in_flit[1] = mk(2'b11, 3'd2, 16'h6104); in_valid[1] = 1'b1;
        @(negedge clk);
        in_valid = '0;
        @(negedge clk);
        chk("R9 both outputs valid", 32'(out_valid), 32'h06);
        chk("R9 output 1 flit", 32'(out_flit[1]), 32'(mk(2'b11, 3'd1, 16'h600D)));
        chk("R9 output 2 flit", 32'(out_flit[2]), 32'(mk(2'b11, 3'd1, 16'h6104)));

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule